// File: doc/BRIEF.md
# Dual-Source Supply Rail Selector

This controller decides which of two supply inputs feeds a shared internal rail. The primary input and the secondary input each report two synchronized comparator flags: one saying the input voltage is high enough to use, and one saying it is too high. The controller qualifies each input, grants the rail to one of them, and drives the enable of that input's pass switch. It raises a ramp flag while the switch is being brought on slowly, and raises power-good once that ramp is finished.

A one-clock strobe arriving once per microsecond is the time base. Each in-range flag has to stay high for a set number of strobes before the input counts. The switch ramp lasts a set number of strobes. Arbitration is first-come, first-served: an input that holds the rail keeps it until it drops out or goes overvoltage. If both inputs qualify on the same clock, the primary input wins. An overvoltage on the selected input removes its switch at once. When the other input is usable, the rail moves over to it with a fresh ramp. There is always one clock between the two switch enables in that case.

Top module: `rail_src_sel`

## Requirements
- R1: During and right after reset, both gate enables, `ramp_active` and `power_good` are low.
- R2: An input qualifies only after its in-range flag has been high on `DEBOUNCE_TICKS` (default 4) consecutive tick strobes. Any low cycle on the flag clears the count.
- R3: If both inputs qualify on the same clock while the rail is unowned, the primary switch (`pri_gate_en`) is enabled.
- R4: Once an input owns the rail, the other input qualifying later does not move the rail.
- R5: When a switch is first enabled, `ramp_active` is high. It stays high for exactly `RAMP_TICKS` (default 300) tick strobes. On the clock of the last of those strobes, `ramp_active` falls and `power_good` rises.
- R6: An overvoltage flag on the selected input turns its gate enable off one clock later, which is well inside the 5-tick limit. An overvoltage flag on the unselected input has no effect on the outputs.
- R7: `pri_gate_en` and `sec_gate_en` are never high together.
- R8: When the selected input is lost while the other input is qualified and free of overvoltage, both enables are low for exactly one clock. The other enable then rises with `ramp_active` high and a fresh ramp.
- R9: When neither input is usable, both enables stay low until an input qualifies. If the selected input's in-range flag falls, its enable is released within two clocks.
- R10: `power_good` is high only while a gate enable is high. It falls on the same clock as the enable.
- R11: An input whose overvoltage flag is high is never selected, even when its in-range flag is qualified.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-clock strobe, once per microsecond |
| pri_in_range | input | 1 | Primary input above its minimum usable level |
| pri_ovp | input | 1 | Primary input above its overvoltage level |
| sec_in_range | input | 1 | Secondary input above its minimum usable level |
| sec_ovp | input | 1 | Secondary input above its overvoltage level |
| pri_gate_en | output | 1 | Enable of the primary pass switch |
| sec_gate_en | output | 1 | Enable of the secondary pass switch |
| ramp_active | output | 1 | Selected switch is in its soft turn-on |
| power_good | output | 1 | Rail is sourced and the ramp has finished |

## Verification
The bench targets these corner cases, each with the failure it would expose:
- **Debounce clearing.** A flag that drops one tick short of qualifying must start its count again. A design that kept the count would grant the rail too early.
- **Same-clock tie.** Both inputs qualify together. A design with the wrong priority would power the secondary input.
- **Late primary arrival.** The primary qualifies after the secondary already owns the rail. A priority-based design would steal the rail, and that would show as a second enable rising.
- **Overvoltage failover.** A design that swaps in one clock would show both enables high or no dead cycle. A design that reuses the old ramp count would raise `power_good` before 300 fresh ticks.
- **Ramp length.** Power-good is checked one tick before and exactly at the 300th tick, which exposes an off-by-one in the ramp counter.

// File: rtl/rail_sel_pkg.sv
package rail_sel_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RAMP = 2'd1,
    ST_ON   = 2'd2,
    ST_SWAP = 2'd3
  } sel_state_e;

  typedef enum logic {
    SRC_PRI = 1'b0,
    SRC_SEC = 1'b1
  } src_e;

  // Gate pattern {sec, pri} for a state and an owner.
  function automatic logic [1:0] gate_decode(sel_state_e st, src_e owner);
    logic drive;
    drive = (st == ST_RAMP) || (st == ST_ON);
    gate_decode = drive ? ((owner == SRC_SEC) ? 2'b10 : 2'b01) : 2'b00;
  endfunction

  // Arbitration on an unowned rail: primary wins a tie.
  function automatic src_e pick_source(logic pri_ok, logic sec_ok);
    pick_source = (pri_ok || !sec_ok) ? SRC_PRI : SRC_SEC;
  endfunction

  function automatic src_e other_source(src_e s);
    other_source = (s == SRC_PRI) ? SRC_SEC : SRC_PRI;
  endfunction

endpackage

// File: rtl/src_qualifier.sv
module src_qualifier #(
  parameter int DEBOUNCE_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic in_range,
  input  logic over_v,
  output logic qualified,
  output logic usable
);
  localparam int CW = $clog2(DEBOUNCE_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DEBOUNCE_TICKS);

  logic [CW-1:0] stable_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable_cnt <= '0;
    end else if (!in_range) begin
      stable_cnt <= '0;
    end else if (tick && (stable_cnt != LIMIT)) begin
      stable_cnt <= stable_cnt + 1'b1;
    end
  end

  assign qualified = (stable_cnt == LIMIT);
  assign usable    = qualified && !over_v;

  // R2: qualification only rises while the flag has been high
  a_r2_rise_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(qualified) |-> $past(in_range));
  // R2: a low flag clears qualification on the next clock
  a_r2_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !in_range |=> !qualified);

endmodule

// File: rtl/ramp_timer.sv
module ramp_timer #(
  parameter int RAMP_TICKS = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic done
);
  localparam int CW = $clog2(RAMP_TICKS);
  localparam logic [CW-1:0] LAST = CW'(RAMP_TICKS - 1);

  logic [CW-1:0] tick_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
    end else if (!run) begin
      tick_cnt <= '0;
    end else if (tick && (tick_cnt != LAST)) begin
      tick_cnt <= tick_cnt + 1'b1;
    end
  end

  assign done = run && tick && (tick_cnt == LAST);

  // R5: a stopped timer always restarts from zero
  a_r5_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (tick_cnt == '0));

endmodule

// File: rtl/sel_fsm.sv
module sel_fsm
  import rail_sel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pri_ok,
  input  logic       sec_ok,
  input  logic       ramp_done,
  output sel_state_e state,
  output src_e       owner
);
  sel_state_e state_n;
  src_e       owner_n;
  logic       cur_ok, alt_ok;

  assign cur_ok = (owner == SRC_PRI) ? pri_ok : sec_ok;
  assign alt_ok = (owner == SRC_PRI) ? sec_ok : pri_ok;

  always_comb begin
    state_n = state;
    owner_n = owner;
    unique case (state)
      ST_IDLE: begin
        if (pri_ok || sec_ok) begin
          owner_n = pick_source(pri_ok, sec_ok);
          state_n = ST_RAMP;
        end
      end
      ST_RAMP, ST_ON: begin
        if (!cur_ok) begin
          if (alt_ok) begin
            owner_n = other_source(owner);
            state_n = ST_SWAP;
          end else begin
            state_n = ST_IDLE;
          end
        end else if (state == ST_RAMP && ramp_done) begin
          state_n = ST_ON;
        end
      end
      ST_SWAP: begin
        state_n = cur_ok ? ST_RAMP : ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      owner <= SRC_PRI;
    end else begin
      state <= state_n;
      owner <= owner_n;
    end
  end

  // R4: a held rail keeps its owner while that owner stays usable
  a_r4_keep_owner: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_RAMP || state == ST_ON) && cur_ok) |=> $stable(owner));

endmodule

// File: rtl/rail_src_sel.sv
module rail_src_sel
  import rail_sel_pkg::*;
#(
  parameter int DEBOUNCE_TICKS = 4,
  parameter int RAMP_TICKS     = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pri_in_range,
  input  logic pri_ovp,
  input  logic sec_in_range,
  input  logic sec_ovp,
  output logic pri_gate_en,
  output logic sec_gate_en,
  output logic ramp_active,
  output logic power_good
);
  logic       pri_qual, sec_qual;
  logic       pri_ok, sec_ok;
  logic       ramp_run, ramp_done;
  logic [1:0] gates;
  sel_state_e state;
  src_e       owner;

  src_qualifier #(.DEBOUNCE_TICKS(DEBOUNCE_TICKS)) u_pri_q (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .in_range(pri_in_range), .over_v(pri_ovp),
    .qualified(pri_qual), .usable(pri_ok));

  src_qualifier #(.DEBOUNCE_TICKS(DEBOUNCE_TICKS)) u_sec_q (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .in_range(sec_in_range), .over_v(sec_ovp),
    .qualified(sec_qual), .usable(sec_ok));

  assign ramp_run = (state == ST_RAMP);

  ramp_timer #(.RAMP_TICKS(RAMP_TICKS)) u_ramp (
    .clk(clk), .rst_n(rst_n), .run(ramp_run), .tick(tick), .done(ramp_done));

  sel_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pri_ok(pri_ok), .sec_ok(sec_ok),
    .ramp_done(ramp_done), .state(state), .owner(owner));

  assign gates       = gate_decode(state, owner);
  assign pri_gate_en = gates[0];
  assign sec_gate_en = gates[1];
  assign ramp_active = ramp_run;
  assign power_good  = (state == ST_ON);

  // R7: the two pass switches are exclusive
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pri_gate_en && sec_gate_en));
  // R6: overvoltage on the driving input drops it on the next clock
  a_r6_pri_ovp_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_gate_en && pri_ovp) |=> !pri_gate_en);
  a_r6_sec_ovp_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_gate_en && sec_ovp) |=> !sec_gate_en);
  // R8: break before make between the two switches
  a_r8_pri_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pri_gate_en) |-> $past(!sec_gate_en));
  a_r8_sec_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_gate_en) |-> $past(!pri_gate_en));
  // R10: power-good never outlives the switch
  a_r10_pg_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    power_good |-> (pri_gate_en || sec_gate_en));
  // R5: power-good only follows a ramp
  a_r5_pg_after_ramp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_good) |-> $past(ramp_active));
  // R9: with no usable input, nothing is driven next
  a_r9_none_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!pri_ok && !sec_ok) |=> !(pri_gate_en || sec_gate_en));
  // R11: an overvoltaged input is never freshly granted
  a_r11_no_ovp_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_ovp && pri_qual && !pri_gate_en) |=> !pri_gate_en);

endmodule

// File: tb/rail_src_sel_tb.sv
module rail_src_sel_tb;
  localparam int DEB  = 4;
  localparam int RAMP = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic p_rng = 1'b0, p_ov = 1'b0, s_rng = 1'b0, s_ov = 1'b0;
  logic p_g, s_g, ramp, pg;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rail_src_sel #(.DEBOUNCE_TICKS(DEB), .RAMP_TICKS(RAMP)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .pri_in_range(p_rng), .pri_ovp(p_ov),
    .sec_in_range(s_rng), .sec_ovp(s_ov),
    .pri_gate_en(p_g), .sec_gate_en(s_g),
    .ramp_active(ramp), .power_good(pg));

  // Expected output vector {pri, sec, ramp, pg}
  function automatic logic [3:0] expect_vec(logic pri, logic sec, logic rmp, logic good);
    return {pri, sec, rmp, good};
  endfunction

  task automatic chk(string req, logic [3:0] exp);
    logic [3:0] act;
    act = {p_g, s_g, ramp, pg};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act={p,s,ramp,pg}=%b exp=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic clear_all();
    p_rng = 0; s_rng = 0; p_ov = 0; s_ov = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #700000;
    errors++;
    $display("FAIL watchdog expired");
    if (!finished) begin
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int rp, rs, qp, qs;
    logic ap, as_, aov_p, aov_s, at;
    void'($urandom(32'd4242));
    @(negedge clk);
    chk("R1", 4'b0000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 4'b0000);

    // R2 debounce: three ticks, drop, three again: not yet
    p_rng = 1;
    ticks(DEB - 1);
    chk("R2", 4'b0000);
    p_rng = 0; @(negedge clk); p_rng = 1;
    ticks(DEB - 1);
    chk("R2", 4'b0000);
    ticks(1);
    chk("R2", expect_vec(1, 0, 1, 0));

    // R5 ramp length
    ticks(RAMP - 1);
    chk("R5", expect_vec(1, 0, 1, 0));
    ticks(1);
    chk("R5", expect_vec(1, 0, 0, 1));

    // R4 secondary qualifies late: no move
    s_rng = 1;
    ticks(DEB + 1);
    chk("R4", expect_vec(1, 0, 0, 1));

    // R6 overvoltage on unselected input: no effect
    s_ov = 1; @(negedge clk); @(negedge clk);
    chk("R6", expect_vec(1, 0, 0, 1));
    s_ov = 0; @(negedge clk);

    // R6/R10/R8 overvoltage on the owner, failover
    p_ov = 1; @(negedge clk);
    chk("R6", expect_vec(0, 0, 0, 0));
    @(negedge clk);
    chk("R8", expect_vec(0, 1, 1, 0));
    p_ov = 0;
    ticks(RAMP - 1);
    chk("R8", expect_vec(0, 1, 1, 0));
    ticks(1);
    chk("R4", expect_vec(0, 1, 0, 1));

    // R9 loss of both
    p_rng = 0; s_rng = 0;
    @(negedge clk); @(negedge clk);
    chk("R9", 4'b0000);
    ticks(DEB + 2);
    chk("R9", 4'b0000);

    // R3 tie
    p_rng = 1; s_rng = 1;
    ticks(DEB);
    chk("R3", expect_vec(1, 0, 1, 0));
    clear_all();
    chk("R9", 4'b0000);

    // R11 overvoltaged primary not taken
    p_ov = 1; p_rng = 1; s_rng = 1;
    ticks(DEB);
    chk("R11", expect_vec(0, 1, 1, 0));
    clear_all();

    // R4 secondary first, primary later
    s_rng = 1;
    ticks(2);
    p_rng = 1;
    ticks(DEB - 2);
    chk("R4", expect_vec(0, 1, 1, 0));
    ticks(3);
    chk("R4", expect_vec(0, 1, 1, 0));
    clear_all();

    // Random phase: R7, R10, and grant legality (R2, R11)
    rp = 0; rs = 0;
    ap = 0; as_ = 0; aov_p = 0; aov_s = 0; at = 0;
    for (int i = 0; i < 4000; i++) begin
      if (p_rng != s_rng || p_rng) begin end
      if (($urandom % 20) == 0) p_rng = ~p_rng;
      if (($urandom % 20) == 0) s_rng = ~s_rng;
      p_ov = (($urandom % 40) == 0);
      s_ov = (($urandom % 40) == 0);
      tick = (($urandom % 3) == 0);
      ap = p_rng; as_ = s_rng; aov_p = p_ov; aov_s = s_ov; at = tick;
      @(negedge clk);
      qp = rp; qs = rs;
      rp = !ap ? 0 : (at && rp < DEB) ? rp + 1 : rp;
      rs = !as_ ? 0 : (at && rs < DEB) ? rs + 1 : rs;
      checks++;
      if (p_g && s_g) begin
        errors++; $display("FAIL R7 act=both exp=one at most");
      end
      checks++;
      if (pg && !(p_g || s_g)) begin
        errors++; $display("FAIL R10 act=pg without gate exp=pg low");
      end
      checks++;
      if (p_g && !(qp >= DEB && !aov_p)) begin
        errors++; $display("FAIL R2 act=pri gate on exp=off (cnt %0d ov %b)", qp, aov_p);
      end
      checks++;
      if (s_g && !(qs >= DEB && !aov_s)) begin
        errors++; $display("FAIL R11 act=sec gate on exp=off (cnt %0d ov %b)", qs, aov_s);
      end
    end
    tick = 0;
    clear_all();
    chk("R9", 4'b0000);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule